// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits beside the load pipeline and decides, for one issuing load, how the load obtains its data when older stores may still be waiting in the store queue. It compares the load against every queue entry at once and gives one of three outcomes. The load can take its bytes straight from the youngest older store that fully holds them. It can be sent back for replay. Or it can go to the data cache because no older store touches it.

Address matching is deliberately narrow. Only the line-index bits 11:4 of the two physical addresses are compared, and overlap within the 16-byte window is judged from the low four bits and the access sizes. A load sitting anywhere inside a store's bytes may forward. There are three exceptions: the load spills past a 16-byte boundary, the store spills past an 8-byte boundary, or the store data has not arrived. The decision is registered, so it appears one clock after the load is presented.

Top module: `sfw_fwd_check`

## Requirements
- R1: While `rst_n` is low and after its release until the first load, `rsp_valid`, `rsp_fwd`, `rsp_replay`, `rsp_cache` are 0 and `rsp_data` is zero.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `ld_valid` high. With it, exactly one of `rsp_fwd`, `rsp_replay`, `rsp_cache` is high. Without it, all three are low.
- R3: An entry takes part only if its valid bit is set and its 7-bit id is older than the load id. "Older" means (load id − store id) modulo 128 lies in 1..63, so ids wrap.
- R4: An entry matches the load when address bits 11:4 are equal and their byte spans overlap. A byte span starts at address bits 3:0 and runs for the access size. Upper address bits are ignored, so aliases match.
- R5: Among matching entries, the youngest is selected. Bit i*N+j of `sq_age_vec` set means entry j is older than entry i. The entry index plays no part.
- R6: If the selected store fully contains the load, has its data ready, and neither crossing rule applies, the response is a forward. The store byte at offset (load addr − store addr) becomes result byte 0. Byte k of an entry's data holds the store byte at its address + k.
- R7: Size codes 0,1,2,3 mean 1,2,4,8 bytes. A forwarded value is sign-extended from its top byte when `ld_signed` is 1 and zero-extended otherwise.
- R8: A matching load whose span runs past its 16-byte block (addr[3:0] + bytes > 16) is replayed.
- R9: A selected store whose span runs past its 8-byte block (addr[2:0] + bytes > 8) causes replay.
- R10: A selected store that overlaps the load without containing it causes replay.
- R11: A selected store whose ready flag is 0 causes replay, even when an older ready store holds the bytes.
- R12: With no matching entry the response is a cache access, and `rsp_data` is zero whenever `rsp_fwd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | PA_W (40) | Load physical address |
| ld_size | input | 2 | Load size code (1/2/4/8 bytes) |
| ld_signed | input | 1 | Sign-extend the forwarded value |
| ld_id | input | ID_W (7) | Load instruction id |
| sq_valid | input | SQ_DEPTH (12) | Entry valid bits |
| sq_addr | input | SQ_DEPTH*PA_W | Store addresses, entry e at [e*PA_W +: PA_W] |
| sq_size | input | SQ_DEPTH*2 | Store size codes |
| sq_data | input | SQ_DEPTH*64 | Store data, byte k at store address + k |
| sq_id | input | SQ_DEPTH*ID_W | Store instruction ids |
| sq_rdy | input | SQ_DEPTH | Store data present |
| sq_age_vec | input | SQ_DEPTH*SQ_DEPTH | Row i, bit j: entry j older than entry i |
| rsp_valid | output | 1 | Decision for last cycle's load |
| rsp_fwd | output | 1 | Load is served by forwarding |
| rsp_replay | output | 1 | Load must replay |
| rsp_cache | output | 1 | No conflict, read the cache |
| rsp_data | output | 64 | Forwarded, extended value |

## Verification
The bench walks loads through every offset class of an 8-byte store, including odd offsets and the last byte. A wrong shift would return neighbouring bytes, and a wrong extension would leave the upper bits clear under a negative top byte. It places loads and stores just across the 16-byte and 8-byte edges, where a missing crossing rule would forward torn data instead of replaying. It stacks two older stores on the same bytes at both index orders, so a picker that used index instead of the age vectors would return the stale value. It also checks id wrap-around and an alias that differs only above bit 11; a wider compare would send that alias to the cache.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int unsigned DW      = 64;
  localparam int unsigned WIN     = 16;  // bytes in the compare window
  localparam int unsigned HALFWIN = 8;   // store may not spill past this

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } sfw_size_e;

  function automatic logic [4:0] size_bytes(input logic [1:0] s);
    return 5'd1 << s;
  endfunction

  // byte span within a two-window field, so a spill past the window shows
  function automatic logic [31:0] span_mask(input logic [3:0] off, input logic [1:0] s);
    return ((32'h1 << size_bytes(s)) - 32'h1) << off;
  endfunction
endpackage

// File: rtl/sfw_entry_cmp.sv
module sfw_entry_cmp
  import sfw_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ID_W   = 7,
  parameter int unsigned IDX_LO = 4,
  parameter int unsigned IDX_HI = 11
) (
  input  logic            ent_valid,
  input  logic [PA_W-1:0] st_addr,
  input  logic [1:0]      st_size,
  input  logic [ID_W-1:0] st_id,
  input  logic [PA_W-1:0] ld_addr,
  input  logic [1:0]      ld_size,
  input  logic [ID_W-1:0] ld_id,
  output logic            hit,
  output logic            covers,
  output logic            st_spill
);
  logic [ID_W-1:0] id_gap;
  logic            is_older;
  logic            idx_eq;
  logic [31:0]     lmask;
  logic [31:0]     smask;
  logic [4:0]      st_end;

  always_comb begin
    id_gap   = ld_id - st_id;
    is_older = ent_valid && (id_gap != '0) && !id_gap[ID_W-1];
    idx_eq   = (ld_addr[IDX_HI:IDX_LO] == st_addr[IDX_HI:IDX_LO]);
    lmask    = span_mask(ld_addr[3:0], ld_size);
    smask    = span_mask(st_addr[3:0], st_size);
    hit      = is_older && idx_eq && ((lmask & smask) != '0);
    covers   = ((lmask & ~smask) == '0);
    st_end   = {2'b00, st_addr[2:0]} + size_bytes(st_size);
    st_spill = (st_end > 5'(HALFWIN));
  end
endmodule

// File: rtl/sfw_pick.sv
module sfw_pick #(
  parameter int unsigned N = 12
) (
  input  logic [N-1:0]   hit,
  input  logic [N*N-1:0] age_vec,
  output logic [N-1:0]   sel
);
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] younger;
    always_comb begin
      for (int j = 0; j < N; j++) begin
        younger[j] = age_vec[j*N + i];
      end
      sel[i] = hit[i] && ((hit & younger) == '0);
    end
  end
endmodule

// File: rtl/sfw_align_ext.sv
module sfw_align_ext
  import sfw_pkg::*;
(
  input  logic [DW-1:0] raw,
  input  logic [2:0]    shift,
  input  logic [1:0]    size,
  input  logic          sgn,
  output logic [DW-1:0] result
);
  logic [DW-1:0] moved;

  always_comb begin
    moved = raw >> {shift, 3'b000};
    unique case (sfw_size_e'(size))
      SZ_BYTE: result = {{(DW-8){sgn & moved[7]}},   moved[7:0]};
      SZ_HALF: result = {{(DW-16){sgn & moved[15]}}, moved[15:0]};
      SZ_WORD: result = {{(DW-32){sgn & moved[31]}}, moved[31:0]};
      default: result = moved;
    endcase
  end
endmodule

// File: rtl/sfw_fwd_check.sv
module sfw_fwd_check
  import sfw_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 12,
  parameter int unsigned PA_W     = 40,
  parameter int unsigned ID_W     = 7,
  parameter int unsigned IDX_LO   = 4,
  parameter int unsigned IDX_HI   = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_valid,
  input  logic [PA_W-1:0]            ld_addr,
  input  logic [1:0]                 ld_size,
  input  logic                       ld_signed,
  input  logic [ID_W-1:0]            ld_id,
  input  logic [SQ_DEPTH-1:0]        sq_valid,
  input  logic [SQ_DEPTH*PA_W-1:0]   sq_addr,
  input  logic [SQ_DEPTH*2-1:0]      sq_size,
  input  logic [SQ_DEPTH*64-1:0]     sq_data,
  input  logic [SQ_DEPTH*ID_W-1:0]   sq_id,
  input  logic [SQ_DEPTH-1:0]        sq_rdy,
  input  logic [SQ_DEPTH*SQ_DEPTH-1:0] sq_age_vec,
  output logic                       rsp_valid,
  output logic                       rsp_fwd,
  output logic                       rsp_replay,
  output logic                       rsp_cache,
  output logic [63:0]                rsp_data
);
  logic [SQ_DEPTH-1:0] hit, covers, spill, sel;

  for (genvar e = 0; e < SQ_DEPTH; e++) begin : g_ent
    sfw_entry_cmp #(
      .PA_W(PA_W), .ID_W(ID_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
    ) u_cmp (
      .ent_valid (sq_valid[e]),
      .st_addr   (sq_addr[e*PA_W +: PA_W]),
      .st_size   (sq_size[e*2 +: 2]),
      .st_id     (sq_id[e*ID_W +: ID_W]),
      .ld_addr   (ld_addr),
      .ld_size   (ld_size),
      .ld_id     (ld_id),
      .hit       (hit[e]),
      .covers    (covers[e]),
      .st_spill  (spill[e])
    );
  end

  sfw_pick #(.N(SQ_DEPTH)) u_pick (
    .hit     (hit),
    .age_vec (sq_age_vec),
    .sel     (sel)
  );

  // one-hot AND-OR mux of the chosen entry
  logic [3:0]    sel_off;
  logic [DW-1:0] sel_data;
  logic          sel_covers, sel_spill, sel_rdy;

  always_comb begin
    sel_off    = '0;
    sel_data   = '0;
    sel_covers = 1'b0;
    sel_spill  = 1'b0;
    sel_rdy    = 1'b0;
    for (int e = 0; e < SQ_DEPTH; e++) begin
      sel_off    = sel_off    | ({4{sel[e]}} & sq_addr[e*PA_W +: 4]);
      sel_data   = sel_data   | ({DW{sel[e]}} & sq_data[e*DW +: DW]);
      sel_covers = sel_covers | (sel[e] & covers[e]);
      sel_spill  = sel_spill  | (sel[e] & spill[e]);
      sel_rdy    = sel_rdy    | (sel[e] & sq_rdy[e]);
    end
  end

  logic       any_hit, ld_spill, can_fwd;
  logic [3:0] byte_shift;
  logic [4:0] ld_end;

  always_comb begin
    any_hit    = |hit;
    ld_end     = {1'b0, ld_addr[3:0]} + size_bytes(ld_size);
    ld_spill   = (ld_end > 5'(WIN));
    can_fwd    = any_hit && sel_covers && !sel_spill && sel_rdy && !ld_spill;
    byte_shift = ld_addr[3:0] - sel_off;
  end

  logic [DW-1:0] ext_data;

  sfw_align_ext u_ext (
    .raw    (sel_data),
    .shift  (byte_shift[2:0]),
    .size   (ld_size),
    .sgn    (ld_signed),
    .result (ext_data)
  );

  // next-state
  logic          nxt_fwd, nxt_replay, nxt_cache, data_en;
  logic [DW-1:0] nxt_data;

  always_comb begin
    nxt_fwd    = ld_valid & can_fwd;
    nxt_replay = ld_valid & any_hit & !can_fwd;
    nxt_cache  = ld_valid & !any_hit;
    nxt_data   = nxt_fwd ? ext_data : '0;
    data_en    = ld_valid | rsp_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fwd    <= 1'b0;
      rsp_replay <= 1'b0;
      rsp_cache  <= 1'b0;
    end else begin
      rsp_valid  <= ld_valid;
      rsp_fwd    <= nxt_fwd;
      rsp_replay <= nxt_replay;
      rsp_cache  <= nxt_cache;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (data_en) begin
      rsp_data <= nxt_data;
    end
  end
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int unsigned SQ_DEPTH = 12,
  parameter int unsigned PA_W     = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_valid,
  input logic [PA_W-1:0]     ld_addr,
  input logic [1:0]          ld_size,
  input logic [SQ_DEPTH-1:0] sq_valid,
  input logic [SQ_DEPTH-1:0] sq_rdy,
  input logic                rsp_valid,
  input logic                rsp_fwd,
  input logic                rsp_replay,
  input logic                rsp_cache,
  input logic [63:0]         rsp_data
);
  logic [4:0] ld_end;
  assign ld_end = {1'b0, ld_addr[3:0]} + (5'd1 << ld_size);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> rsp_valid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !rsp_valid);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_fwd, rsp_replay, rsp_cache}) == 1));
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_fwd, rsp_replay, rsp_cache} == 3'b000));
  assert_no_fwd_spill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_end > 5'd16)) |=> !rsp_fwd);
  assert_no_fwd_unready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (sq_rdy == '0)) |=> !rsp_fwd);
  assert_empty_to_cache_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (sq_valid == '0)) |=> rsp_cache);
  assert_data_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fwd |-> (rsp_data == 64'd0));
endmodule

bind sfw_fwd_check sfw_checker #(.SQ_DEPTH(SQ_DEPTH), .PA_W(PA_W)) i_sfw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_valid   (ld_valid),
  .ld_addr    (ld_addr),
  .ld_size    (ld_size),
  .sq_valid   (sq_valid),
  .sq_rdy     (sq_rdy),
  .rsp_valid  (rsp_valid),
  .rsp_fwd    (rsp_fwd),
  .rsp_replay (rsp_replay),
  .rsp_cache  (rsp_cache),
  .rsp_data   (rsp_data)
);

// File: tb/test_sfw_fwd_check.sv
`timescale 1ns/1ps
module test_sfw_fwd_check;
  localparam int N   = 12;
  localparam int PA  = 40;
  localparam int IDW = 7;
  localparam logic [63:0] SDATA = 64'h8877_6655_4433_2211;

  localparam logic [1:0] K_CACHE = 2'd0, K_FWD = 2'd1, K_RPL = 2'd2;

  typedef struct packed {
    logic [39:0] ld_addr;
    logic [1:0]  ld_size;
    logic        ld_sgn;
    logic [6:0]  ld_id;
    logic [39:0] st_addr;
    logic [1:0]  st_size;
    logic [6:0]  st_id;
    logic        st_rdy;
    logic [1:0]  kind;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t [0:16] VT = '{
    '{40'h100, 2'd3, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'h8877665544332211, 4'd6},  // R6
    '{40'h103, 2'd0, 1'b1, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'h44,               4'd7},  // R7
    '{40'h107, 2'd0, 1'b1, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'hFFFFFFFFFFFFFF88, 4'd7},  // R7
    '{40'h106, 2'd1, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'h8877,             4'd6},  // R6
    '{40'h104, 2'd2, 1'b1, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'hFFFFFFFF88776655, 4'd7},  // R7
    '{40'h105, 2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_RPL,   64'h0,                4'd10}, // R10
    '{40'h108, 2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_CACHE, 64'h0,                4'd12}, // R12
    '{40'h101, 2'd1, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'h3322,             4'd6},  // R6
    '{40'h10E, 2'd1, 1'b0, 7'd10, 40'h10C, 2'd2, 7'd5, 1'b1, K_FWD,   64'h4433,             4'd6},  // R6
    '{40'h10E, 2'd2, 1'b0, 7'd10, 40'h10C, 2'd2, 7'd5, 1'b1, K_RPL,   64'h0,                4'd8},  // R8
    '{40'h106, 2'd1, 1'b0, 7'd10, 40'h106, 2'd2, 7'd5, 1'b1, K_RPL,   64'h0,                4'd9},  // R9
    '{40'h100, 2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b0, K_RPL,   64'h0,                4'd11}, // R11
    '{40'h1100,2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'h44332211,         4'd4},  // R4
    '{40'h200, 2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_CACHE, 64'h0,                4'd4},  // R4
    '{40'h100, 2'd2, 1'b0, 7'd10, 40'h100, 2'd3, 7'd12,1'b1, K_CACHE, 64'h0,                4'd3},  // R3
    '{40'h100, 2'd0, 1'b0, 7'd2,  40'h100, 2'd3, 7'd127,1'b1,K_FWD,   64'h11,               4'd3},  // R3
    '{40'h106, 2'd1, 1'b1, 7'd10, 40'h100, 2'd3, 7'd5, 1'b1, K_FWD,   64'hFFFFFFFFFFFF8877, 4'd7}   // R7
  };

  logic            clk, rst_n, ld_valid, ld_signed;
  logic [PA-1:0]   ld_addr;
  logic [1:0]      ld_size;
  logic [IDW-1:0]  ld_id;
  logic [N-1:0]    sq_valid, sq_rdy;
  logic [N*PA-1:0] sq_addr;
  logic [N*2-1:0]  sq_size;
  logic [N*64-1:0] sq_data;
  logic [N*IDW-1:0] sq_id;
  logic [N*N-1:0]  sq_age_vec;
  logic            rsp_valid, rsp_fwd, rsp_replay, rsp_cache;
  logic [63:0]     rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sfw_fwd_check #(.SQ_DEPTH(N), .PA_W(PA), .ID_W(IDW)) i_sfw_fwd_check (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_size(ld_size), .ld_signed(ld_signed), .ld_id(ld_id),
    .sq_valid(sq_valid), .sq_addr(sq_addr), .sq_size(sq_size),
    .sq_data(sq_data), .sq_id(sq_id), .sq_rdy(sq_rdy), .sq_age_vec(sq_age_vec),
    .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_replay(rsp_replay),
    .rsp_cache(rsp_cache), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic clear_sq();
    sq_valid = '0; sq_rdy = '0; sq_addr = '0; sq_size = '0;
    sq_data = '0; sq_id = '0; sq_age_vec = '0;
  endtask

  task automatic put(input int e, input logic [39:0] a, input logic [1:0] s,
                     input logic [63:0] d, input logic [6:0] id, input logic r);
    sq_valid[e] = 1'b1;
    sq_rdy[e]   = r;
    sq_addr[e*PA +: PA]   = a;
    sq_size[e*2 +: 2]     = s;
    sq_data[e*64 +: 64]   = d;
    sq_id[e*IDW +: IDW]   = id;
  endtask

  task automatic check(input string tag, input logic [3:0] got_k, input logic [63:0] got_d,
                       input logic [3:0] exp_k, input logic [63:0] exp_d);
    checks++;
    if (got_k !== exp_k || got_d !== exp_d) begin
      errors++;
      $display("FAIL %s: got {valid,fwd,replay,cache}=%b data=%h, expected %b data=%h",
               tag, got_k, got_d, exp_k, exp_d);
    end
  endtask

  task automatic issue(input string tag, input logic [39:0] a, input logic [1:0] s,
                       input logic sg, input logic [6:0] id,
                       input logic [1:0] kind, input logic [63:0] exp);
    logic [3:0] ek;
    @(negedge clk);
    ld_addr = a; ld_size = s; ld_signed = sg; ld_id = id; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    ek = (kind == K_FWD) ? 4'b1100 : (kind == K_RPL) ? 4'b1010 : 4'b1001;
    check(tag, {rsp_valid, rsp_fwd, rsp_replay, rsp_cache}, rsp_data, ek,
          (kind == K_FWD) ? exp : 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_addr = '0; ld_size = '0;
    ld_signed = 1'b0; ld_id = '0;
    clear_sq();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 in reset", {rsp_valid, rsp_fwd, rsp_replay, rsp_cache}, rsp_data, 4'b0000, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rsp_valid, rsp_fwd, rsp_replay, rsp_cache}, rsp_data, 4'b0000, 64'd0);

    // table walk, single store in entry 0
    for (int k = 0; k < 17; k++) begin
      clear_sq();
      put(0, VT[k].st_addr, VT[k].st_size, SDATA, VT[k].st_id, VT[k].st_rdy);
      issue($sformatf("R%0d vector %0d", VT[k].req, k), VT[k].ld_addr, VT[k].ld_size,
            VT[k].ld_sgn, VT[k].ld_id, VT[k].kind, VT[k].exp);
    end

    // R2: no load, no response
    @(negedge clk);
    check("R2 idle", {rsp_valid, rsp_fwd, rsp_replay, rsp_cache}, rsp_data, 4'b0000, 64'd0);

    // R12: empty queue goes to cache
    clear_sq();
    issue("R12 empty queue", 40'h100, 2'd3, 1'b0, 7'd10, K_CACHE, 64'd0);

    // R5: two older stores on the same bytes, younger at higher index
    clear_sq();
    put(3, 40'h100, 2'd3, SDATA,        7'd5, 1'b1);
    put(7, 40'h100, 2'd2, 64'hDDCCBBAA, 7'd7, 1'b1);
    sq_age_vec[7*N + 3] = 1'b1;
    issue("R5 younger at high index", 40'h100, 2'd2, 1'b0, 7'd10, K_FWD, 64'hDDCCBBAA);
    // R3: load between the two stores sees only the older one
    issue("R3 load between stores", 40'h100, 2'd2, 1'b0, 7'd6, K_FWD, 64'h44332211);
    // R11: youngest not ready blocks forwarding from the older one
    sq_rdy[7] = 1'b0;
    issue("R11 youngest unready", 40'h100, 2'd2, 1'b0, 7'd10, K_RPL, 64'd0);

    // R5: younger at lower index
    clear_sq();
    put(2, 40'h100, 2'd2, 64'hDDCCBBAA, 7'd8, 1'b1);
    put(9, 40'h100, 2'd3, SDATA,        7'd4, 1'b1);
    sq_age_vec[2*N + 9] = 1'b1;
    issue("R5 younger at low index", 40'h100, 2'd2, 1'b0, 7'd10, K_FWD, 64'hDDCCBBAA);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule